// File: doc/BRIEF.md
# Two-Level Crossbar Allocator for a Cut-Through Router

This block decides, every cycle, which buffered packets may cross the switch of a virtual cut-through router. Each input port owns a small buffer of candidate packets. For every entry the surrounding logic reports whether it is ready, which output it wants, whether it is a response or a request, and whether it was injected by the local node or arrived from the network. A per-input nominator picks one eligible entry. A per-output selector then picks one nominee among those aimed at that output.

A granted input keeps its crossbar path from the next cycle until the cycle in which its tail flit passes. A 3-flit request and an 18-flit data packet are held in the same way. While a path is held, its output is shown as busy to every nominator. Its input makes no new nomination. A nominee that loses at the output stage is simply dropped. The input may offer another entry on the following cycle.

Both stages rank candidates the same way. Packets already in the network outrank local injections. Among those, responses outrank requests. Remaining ties go to the candidate that was granted least recently.

Top module: `switch_arbiter`

## Requirements
- R1: An entry can be granted only if it is ready, its target output has `out_free` high, and that output is not carrying a packet.
- R2: At both stages a network packet (`ent_inj` = 0) wins over an injected packet (`ent_inj` = 1), whatever their classes.
- R3: Between candidates with equal injection status, a response (`ent_rsp` = 1) wins over a request (`ent_rsp` = 0).
- R4: Among equally ranked entries of one input, the entry granted least recently wins. After reset, lower entry indices count as older.
- R5: Among equally ranked nominees for one output, the input granted least recently wins. After reset, lower input indices count as older.
- R6: Each output grants at most one input per cycle. From the cycle after a grant, `xbar_vld` for that output is high and `xbar_src` holds the granted input index. Both stay unchanged until the tail cycle.
- R7: An input whose nomination loses at the output stage gets no grant in that cycle. On a later cycle it may be granted a different entry aimed at another output.
- R8: A `pkt_tail` pulse on an input holding a path frees that output at the next edge, and the output can be granted again in the cycle after that. A `pkt_tail` pulse on an input holding no path has no effect.
- R9: After reset, no grant is issued and no crossbar path is active until entries are offered.
- R10: An input that holds a path receives no new grant until its tail has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_rdy | input | NIN*DEPTH | Entry ready, bit i*DEPTH+e for entry e of input i |
| ent_tgt | input | NIN*DEPTH*OW | Target output index per entry |
| ent_rsp | input | NIN*DEPTH | 1 = response class, 0 = request class |
| ent_inj | input | NIN*DEPTH | 1 = injected locally, 0 = arrived from the network |
| out_free | input | NOUT | Output can accept a new packet downstream |
| pkt_tail | input | NIN | Tail flit of the input's held packet passes this cycle |
| gnt_vld | output | NIN | Grant issued to the input this cycle |
| gnt_ent | output | NIN*EW | Granted entry index per input |
| xbar_vld | output | NOUT | Output is carrying a packet |
| xbar_src | output | NOUT*IW | Input index connected to each output |

## Verification
Grants are combinational. `gnt_vld` and `gnt_ent` reflect the entry flags driven in the same cycle. `xbar_vld` and `xbar_src` change one clock edge after the grant. The release caused by a tail pulse also shows one edge later, and a fresh grant on the freed output is then visible in that same cycle. The bench drives stimulus 1 ns after a rising edge and reads grants 1 ns later, in the same cycle. It reads path state only after the following edge. Least-recently-granted orderings are tested from a fresh reset, so the expected winners follow from index order and the grants made since.

// File: rtl/swarb_pkg.sv
// Package: shared ranking type for the crossbar allocator.
// Assumes rank is compared as an unsigned number, larger wins.
package swarb_pkg;
    // Rank: bit 1 = arrived from network, bit 0 = response class
    typedef logic [1:0] rank_t;

    // Build the rank so the network-over-injection rule outweighs class
    function automatic rank_t make_rank(input logic injected, input logic response);
        return {~injected, response};
    endfunction
endpackage

// File: rtl/lrs_rank_arb.sv
// Ranked least-recently-selected arbiter.
// Picks, among requesters holding the highest rank, the one granted
// least recently. Keeps an N x N age matrix: older[a][b] = 1 means a
// has precedence over b. Assumes upd is only meaningful when a winner
// exists; the matrix is left alone otherwise.
module lrs_rank_arb
    import swarb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  rank_t         rank [N],
    input  logic          upd,
    output logic [N-1:0]  win
);
    logic [N-1:0] older [N];
    rank_t        top_rank;
    logic [N-1:0] elig;

    // Find the best rank present among requesters
    always_comb begin
        top_rank = '0;
        for (int c = 0; c < N; c++)
            if (req[c] && rank[c] > top_rank) top_rank = rank[c];
    end

    // Keep the top-ranked requesters, then the oldest among them
    always_comb begin
        for (int c = 0; c < N; c++) elig[c] = req[c] && (rank[c] == top_rank);
        for (int c = 0; c < N; c++) begin
            win[c] = elig[c];
            for (int d = 0; d < N; d++)
                if (d != c && elig[d] && !older[c][d]) win[c] = 1'b0;
        end
    end

    // Age update: the winner becomes the youngest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++) older[a][b] <= (a < b);
        end else if (upd && |win) begin
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++)
                    if (a != b) begin
                        if (win[a])      older[a][b] <= 1'b0;
                        else if (win[b]) older[a][b] <= 1'b1;
                    end
        end
    end
endmodule

// File: rtl/input_nominator.sv
// Per-input local stage: offers one buffered packet per cycle.
// An entry qualifies if it is ready, its target output is open, and
// the input holds no path. The age order advances only when the
// offered entry is actually granted by the output stage.
module input_nominator
    import swarb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NOUT  = 4,
    localparam int OW   = (NOUT > 1) ? $clog2(NOUT) : 1,
    localparam int EW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  rdy,
    input  logic [OW-1:0]     tgt [DEPTH],
    input  logic [DEPTH-1:0]  rsp,
    input  logic [DEPTH-1:0]  inj,
    input  logic [NOUT-1:0]   out_open,
    input  logic              held,
    input  logic              granted,
    output logic              nom_vld,
    output logic [EW-1:0]     nom_ent,
    output logic [OW-1:0]     nom_tgt,
    output rank_t             nom_rank
);
    logic [DEPTH-1:0] cand;
    rank_t            erank [DEPTH];
    logic [DEPTH-1:0] pick;

    // Qualify entries and rank them
    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            cand[e]  = rdy[e] && out_open[tgt[e]] && !held;
            erank[e] = make_rank(inj[e], rsp[e]);
        end
    end

    lrs_rank_arb #(.N(DEPTH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cand),
        .rank  (erank),
        .upd   (granted),
        .win   (pick)
    );

    // Encode the one-hot pick into the offered entry's fields
    always_comb begin
        nom_vld  = |pick;
        nom_ent  = '0;
        nom_tgt  = '0;
        nom_rank = '0;
        for (int e = 0; e < DEPTH; e++)
            if (pick[e]) begin
                nom_ent  = EW'(e);
                nom_tgt  = tgt[e];
                nom_rank = erank[e];
            end
    end
endmodule

// File: rtl/switch_arbiter.sv
// Top: two-level crossbar allocator for a cut-through router.
// One input_nominator per input offers a packet; one ranked LRS
// arbiter per output picks among offers aimed at it. A grant holds the
// output from the next cycle until the edge after the tail pulse.
// Assumes the buffer withdraws a granted entry's ready flag itself.
module switch_arbiter
    import swarb_pkg::*;
#(
    parameter int NIN   = 4,
    parameter int NOUT  = 4,
    parameter int DEPTH = 4,
    localparam int OW   = (NOUT > 1) ? $clog2(NOUT) : 1,
    localparam int EW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW   = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NIN*DEPTH-1:0]     ent_rdy,
    input  logic [NIN*DEPTH*OW-1:0]  ent_tgt,
    input  logic [NIN*DEPTH-1:0]     ent_rsp,
    input  logic [NIN*DEPTH-1:0]     ent_inj,
    input  logic [NOUT-1:0]          out_free,
    input  logic [NIN-1:0]           pkt_tail,
    output logic [NIN-1:0]           gnt_vld,
    output logic [NIN*EW-1:0]        gnt_ent,
    output logic [NOUT-1:0]          xbar_vld,
    output logic [NOUT*IW-1:0]       xbar_src
);
    logic [NOUT-1:0] out_open;
    logic [NIN-1:0]  held;
    logic [NIN-1:0]  nom_vld;
    logic [EW-1:0]   nom_ent  [NIN];
    logic [OW-1:0]   nom_tgt  [NIN];
    rank_t           nom_rank [NIN];
    logic [NIN-1:0]  gwin     [NOUT];
    logic [IW-1:0]   src_q    [NOUT];

    // An output is open when downstream is free and no packet is in flight
    assign out_open = out_free & ~xbar_vld;

    // An input is held while any output is connected to it
    always_comb begin
        held = '0;
        for (int o = 0; o < NOUT; o++)
            if (xbar_vld[o]) held[src_q[o]] = 1'b1;
    end

    // Local stage, one per input
    for (genvar i = 0; i < NIN; i++) begin : g_in
        logic [OW-1:0] tgt_i [DEPTH];
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            assign tgt_i[e] = ent_tgt[(i*DEPTH+e)*OW +: OW];
        end
        input_nominator #(.DEPTH(DEPTH), .NOUT(NOUT)) u_nom (
            .clk      (clk),
            .rst_n    (rst_n),
            .rdy      (ent_rdy[i*DEPTH +: DEPTH]),
            .tgt      (tgt_i),
            .rsp      (ent_rsp[i*DEPTH +: DEPTH]),
            .inj      (ent_inj[i*DEPTH +: DEPTH]),
            .out_open (out_open),
            .held     (held[i]),
            .granted  (gnt_vld[i]),
            .nom_vld  (nom_vld[i]),
            .nom_ent  (nom_ent[i]),
            .nom_tgt  (nom_tgt[i]),
            .nom_rank (nom_rank[i])
        );
        assign gnt_ent[i*EW +: EW] = nom_ent[i];
    end

    // Global stage, one per output
    for (genvar o = 0; o < NOUT; o++) begin : g_out
        logic [NIN-1:0] oreq;
        always_comb begin
            for (int i = 0; i < NIN; i++)
                oreq[i] = nom_vld[i] && (nom_tgt[i] == OW'(o));
        end
        lrs_rank_arb #(.N(NIN)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (oreq),
            .rank  (nom_rank),
            .upd   (1'b1),
            .win   (gwin[o])
        );
        assign xbar_src[o*IW +: IW] = src_q[o];
    end

    // Collect grants: each input offers one target, so at most one output grants it
    always_comb begin
        gnt_vld = '0;
        for (int o = 0; o < NOUT; o++) gnt_vld = gnt_vld | gwin[o];
    end

    // Path hold: set on grant, clear at the edge after the holder's tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xbar_vld <= '0;
            for (int o = 0; o < NOUT; o++) src_q[o] <= '0;
        end else begin
            for (int o = 0; o < NOUT; o++) begin
                if (xbar_vld[o]) begin
                    if (pkt_tail[src_q[o]]) xbar_vld[o] <= 1'b0;
                end else if (|gwin[o]) begin
                    xbar_vld[o] <= 1'b1;
                    for (int i = 0; i < NIN; i++)
                        if (gwin[o][i]) src_q[o] <= IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/swarb_chk.sv
// Checker for switch_arbiter, bound to every instance.
// Observes only top-level ports; derives granted targets from the
// entry fields and the granted entry index.
module swarb_chk #(
    parameter int NIN   = 4,
    parameter int NOUT  = 4,
    parameter int DEPTH = 4,
    localparam int OW   = (NOUT > 1) ? $clog2(NOUT) : 1,
    localparam int EW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW   = (NIN > 1) ? $clog2(NIN) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NIN*DEPTH-1:0]     ent_rdy,
    input logic [NIN*DEPTH*OW-1:0]  ent_tgt,
    input logic [NIN*DEPTH-1:0]     ent_rsp,
    input logic [NIN*DEPTH-1:0]     ent_inj,
    input logic [NOUT-1:0]          out_free,
    input logic [NIN-1:0]           pkt_tail,
    input logic [NIN-1:0]           gnt_vld,
    input logic [NIN*EW-1:0]        gnt_ent,
    input logic [NOUT-1:0]          xbar_vld,
    input logic [NOUT*IW-1:0]       xbar_src
);
    logic [OW-1:0]  g_tgt   [NIN];
    logic [NIN-1:0] g_rdy;
    logic [NIN-1:0] held;
    logic [NIN-1:0] on_out  [NOUT];
    logic [IW-1:0]  src     [NOUT];
    logic [IW-1:0]  new_src [NOUT];
    logic [NOUT-1:0] tail_o;

    // Decode what each grant refers to and who holds each output
    always_comb begin
        held = '0;
        for (int i = 0; i < NIN; i++) begin
            g_tgt[i] = ent_tgt[(i*DEPTH + int'(gnt_ent[i*EW +: EW]))*OW +: OW];
            g_rdy[i] = ent_rdy[i*DEPTH + int'(gnt_ent[i*EW +: EW])];
        end
        for (int o = 0; o < NOUT; o++) begin
            src[o]     = xbar_src[o*IW +: IW];
            tail_o[o]  = pkt_tail[src[o]];
            new_src[o] = '0;
            if (xbar_vld[o]) held[src[o]] = 1'b1;
            for (int i = 0; i < NIN; i++) begin
                on_out[o][i] = gnt_vld[i] && (g_tgt[i] == OW'(o));
                if (on_out[o][i]) new_src[o] = IW'(i);
            end
        end
    end

    for (genvar i = 0; i < NIN; i++) begin : g_ai
        p_gnt_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[i] |-> g_rdy[i] && out_free[g_tgt[i]] && !xbar_vld[g_tgt[i]]);
        p_held_no_gnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
            held[i] |-> !gnt_vld[i]);
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_ao
        p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(on_out[o]) <= 1);
        p_path_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|on_out[o]) |=> xbar_vld[o] && (src[o] == $past(new_src[o])));
        p_path_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (xbar_vld[o] && !tail_o[o]) |=> xbar_vld[o] && $stable(src[o]));
        p_path_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (xbar_vld[o] && tail_o[o]) |=> !xbar_vld[o]);
        p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
            xbar_vld[o] |-> on_out[o] == '0);
    end
endmodule

bind switch_arbiter swarb_chk #(.NIN(NIN), .NOUT(NOUT), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_switch_arbiter.sv
`timescale 1ns/100ps
module tb_switch_arbiter;
    localparam int NIN = 4, NOUT = 4, DEPTH = 4;
    localparam int OW = 2, EW = 2, IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NIN*DEPTH-1:0]    ent_rdy = '0;
    logic [NIN*DEPTH*OW-1:0] ent_tgt = '0;
    logic [NIN*DEPTH-1:0]    ent_rsp = '0;
    logic [NIN*DEPTH-1:0]    ent_inj = '0;
    logic [NOUT-1:0]         out_free = '1;
    logic [NIN-1:0]          pkt_tail = '0;
    logic [NIN-1:0]          gnt_vld;
    logic [NIN*EW-1:0]       gnt_ent;
    logic [NOUT-1:0]         xbar_vld;
    logic [NOUT*IW-1:0]      xbar_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    switch_arbiter #(.NIN(NIN), .NOUT(NOUT), .DEPTH(DEPTH)) dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        ent_rdy = '0; ent_tgt = '0; ent_rsp = '0; ent_inj = '0;
        out_free = '1; pkt_tail = '0;
    endtask

    task automatic set_ent(input int i, input int e, input int tgt, input bit rsp, input bit inj);
        ent_rdy[i*DEPTH+e] = 1'b1;
        ent_tgt[(i*DEPTH+e)*OW +: OW] = OW'(tgt);
        ent_rsp[i*DEPTH+e] = rsp;
        ent_inj[i*DEPTH+e] = inj;
    endtask

    function automatic int gent(input int i);
        return int'(gnt_ent[i*EW +: EW]);
    endfunction

    function automatic int src(input int o);
        return int'(xbar_src[o*IW +: IW]);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        clear_all();
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // Pulse the tail of input i and let the release edge pass
    task automatic tail_of(input int i);
        pkt_tail[i] = 1'b1;
        tick();
        pkt_tail[i] = 1'b0;
        #1;
    endtask

    initial begin
        tick();
        do_reset();
        #1;
        // R9: idle after reset
        check("R9 gnt_vld", int'(gnt_vld), 0);
        check("R9 xbar_vld", int'(xbar_vld), 0);
        tick();

        // R1/R6/R8 sweep: a lone entry on every input, slot and output
        for (int i = 0; i < NIN; i++)
            for (int e = 0; e < DEPTH; e++)
                for (int o = 0; o < NOUT; o++) begin
                    clear_all();
                    set_ent(i, e, o, 1'b0, 1'b0);
                    #1;
                    check("R1 sweep gnt_vld", int'(gnt_vld), 1 << i);
                    check("R1 sweep gnt_ent", gent(i), e);
                    tick();
                    ent_rdy = '0;
                    #1;
                    check("R6 sweep xbar_vld", int'(xbar_vld), 1 << o);
                    check("R6 sweep xbar_src", src(o), i);
                    tail_of(i);
                    check("R8 sweep release", int'(xbar_vld), 0);
                    tick();
                end

        // R1: blocked downstream output
        do_reset();
        set_ent(0, 0, 3, 1'b0, 1'b0);
        out_free = 4'b0111;
        #1;
        check("R1 out_free low", int'(gnt_vld), 0);
        out_free = 4'b1111;
        #1;
        check("R1 out_free high", int'(gnt_vld), 1);

        // R2 local: network request beats injected response
        do_reset();
        set_ent(0, 0, 0, 1'b1, 1'b1);
        set_ent(0, 1, 1, 1'b0, 1'b0);
        #1;
        check("R2 local entry", gent(0), 1);

        // R3 local: response beats request
        do_reset();
        set_ent(0, 0, 0, 1'b0, 1'b0);
        set_ent(0, 1, 1, 1'b1, 1'b0);
        #1;
        check("R3 local entry", gent(0), 1);

        // R2 global: network input beats injecting input
        do_reset();
        set_ent(0, 0, 2, 1'b1, 1'b1);
        set_ent(1, 0, 2, 1'b0, 1'b0);
        #1;
        check("R2 global winner", int'(gnt_vld), 4'b0010);

        // R3 global: response input beats request input
        do_reset();
        set_ent(0, 0, 2, 1'b0, 1'b0);
        set_ent(2, 0, 2, 1'b1, 1'b0);
        #1;
        check("R3 global winner", int'(gnt_vld), 4'b0100);

        // R4: equal entries alternate by least recent grant
        do_reset();
        set_ent(0, 0, 0, 1'b0, 1'b0);
        set_ent(0, 1, 1, 1'b0, 1'b0);
        #1;
        check("R4 first", gent(0), 0);
        tick(); tail_of(0);
        check("R4 second", gent(0), 1);
        tick(); tail_of(0);
        check("R4 third", gent(0), 0);

        // R5: three inputs share one output in rotation
        do_reset();
        set_ent(0, 0, 0, 1'b0, 1'b0);
        set_ent(1, 0, 0, 1'b0, 1'b0);
        set_ent(2, 0, 0, 1'b0, 1'b0);
        #1;
        check("R5 round 1", int'(gnt_vld), 4'b0001);
        tick(); tail_of(0);
        check("R5 round 2", int'(gnt_vld), 4'b0010);
        tick(); tail_of(1);
        check("R5 round 3", int'(gnt_vld), 4'b0100);
        tick(); tail_of(2);
        check("R5 round 4", int'(gnt_vld), 4'b0001);

        // R7: loser withdraws, then wins another output
        do_reset();
        set_ent(0, 0, 0, 1'b0, 1'b0);
        set_ent(0, 1, 1, 1'b0, 1'b0);
        set_ent(1, 0, 0, 1'b1, 1'b0);
        #1;
        check("R7 loser withdrawn", int'(gnt_vld), 4'b0010);
        tick();
        check("R7 renominated grant", int'(gnt_vld), 4'b0001);
        check("R7 renominated entry", gent(0), 1);
        tick();
        // R10: held inputs get nothing new
        set_ent(0, 2, 2, 1'b0, 1'b0);
        #1;
        check("R10 held input", int'(gnt_vld), 0);
        // R8: tail on an idle input is ignored
        tail_of(3);
        check("R8 idle tail ignored", int'(xbar_vld), 4'b0011);
        tail_of(1);
        check("R8 one path released", int'(xbar_vld), 4'b0010);
        check("R10 still held", int'(gnt_vld[0]), 0);

        // R6: an 18-flit data packet keeps its path throughout
        do_reset();
        set_ent(2, 0, 3, 1'b0, 1'b0);
        #1;
        check("R6 long grant", int'(gnt_vld), 4'b0100);
        tick();
        ent_rdy = '0;
        for (int k = 1; k < 18; k++) begin
            #1;
            check("R6 long hold vld", int'(xbar_vld), 4'b1000);
            check("R6 long hold src", src(3), 2);
            tick();
        end
        #1;
        check("R6 long tail cycle", int'(xbar_vld), 4'b1000);
        tail_of(2);
        check("R8 long release", int'(xbar_vld), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule